// File: doc/BRIEF.md
# Output Clock Stop and Power-Down Gate

This block sits between free-running clock sources and the output pads of a clock generator. It drives seven output groups: CPU differential pairs, SRC differential pairs, PCI and PCIF single-ended clocks, a 48 MHz USB clock, a 96 MHz differential dot clock and the reference clock. For every output it produces the level to drive on each side and a drive-enable for each side. A low drive-enable means the pad floats. It handles three kinds of control: a static enable per output, a software stop that freezes selected PCI-class outputs, and an asynchronous power-down input. It also owns the VCO enable.

Each source clock has its own domain. The stop and park requests are resynchronized into every domain, and each gate changes only at the clock edge where the parked level already matches the running level. A single-ended output therefore stops on a falling edge, and a pair parked high stops on a rising edge. Power-down is sequenced from the reference domain. It parks every group, waits until all groups confirm they are parked, and then drops the VCO enable. On release the VCO is enabled again at once. The outputs stay parked for a stabilization count of reference cycles, and during that count every parked pair drives its true side high. The same hold applies after reset.

Top module: `clk_stop_gate`

## Requirements
- R1: With no stop and no power-down in effect, an output whose enable bit is 1 drives its source clock on the true side and the inverted clock on the complement side, and both drive-enables are 1. An output whose enable bit is 0 has every drive-enable at 0.
- R2: With `sw_stop` at 1, every PCI output is held low. Each PCIF and SRC output whose stop-select bit is 1 is stopped. An output whose stop-select bit is 0 keeps running as in R1.
- R3: A stopped SRC pair drives its complement low. Its true side is driven high when `src_stop_tri` is 0 and floats (true drive-enable 0) when `src_stop_tri` is 1.
- R4: `sw_stop` has no effect on the CPU pairs, the dot pair, USB or REF.
- R5: During power-down, the PCI, PCIF, USB and REF outputs are held low while their drive-enables follow their enable bits.
- R6: During power-down, the complement side of every CPU pair, SRC pair and the dot pair floats. The true side is driven high when the pair's power-down tristate bit is 0 and floats when that bit is 1. There is one such bit per CPU pair, one for the whole SRC group and one for the dot pair.
- R7: `vco_en` falls only after every output group has parked, and it stays low while `pd` is held high.
- R8: When `pd` is released, `vco_en` returns to 1. All outputs stay parked for `STAB_CYCLES` reference cycles, and during that time every enabled pair drives its true side high whatever its tristate bit says. After that time the outputs run again.
- R9: After reset the block behaves as in R8: `vco_en` is 1 and the outputs stay parked until the stabilization count expires, after which they run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock; also sequences power-down |
| cpu_clk | input | 1 | CPU group source clock |
| src_clk | input | 1 | SRC group source clock |
| pci_clk | input | 1 | PCI and PCIF source clock |
| usb_clk | input | 1 | 48 MHz source clock |
| dot_clk | input | 1 | 96 MHz source clock |
| pd | input | 1 | Asynchronous power-down request, active high |
| sw_stop | input | 1 | Software stop for PCI, PCIF and SRC |
| cpu_en | input | NCPU | Per CPU pair enable, 1 = drive |
| src_en | input | NSRC | Per SRC pair enable, 1 = drive |
| pci_en | input | NPCI | Per PCI output enable |
| pcif_en | input | NPCIF | Per PCIF output enable |
| usb_en | input | 1 | USB output enable |
| dot_en | input | 1 | Dot pair enable |
| ref_en | input | 1 | REF output enable |
| src_stop_sel | input | NSRC | 1 = SRC pair obeys sw_stop, 0 = free-running |
| pcif_stop_sel | input | NPCIF | 1 = PCIF output obeys sw_stop, 0 = free-running |
| src_stop_tri | input | 1 | 1 = stopped SRC true side floats |
| cpu_pd_tri | input | NCPU | 1 = CPU pair fully floats in power-down |
| src_pd_tri | input | 1 | 1 = SRC pairs fully float in power-down |
| dot_pd_tri | input | 1 | 1 = dot pair fully floats in power-down |
| cpu_p | output | NCPU | CPU true-side level |
| cpu_n | output | NCPU | CPU complement level |
| cpu_p_oe | output | NCPU | CPU true-side drive enable |
| cpu_n_oe | output | NCPU | CPU complement drive enable |
| src_p | output | NSRC | SRC true-side level |
| src_n | output | NSRC | SRC complement level |
| src_p_oe | output | NSRC | SRC true-side drive enable |
| src_n_oe | output | NSRC | SRC complement drive enable |
| dot_p | output | 1 | Dot true-side level |
| dot_n | output | 1 | Dot complement level |
| dot_p_oe | output | 1 | Dot true-side drive enable |
| dot_n_oe | output | 1 | Dot complement drive enable |
| pci_o | output | NPCI | PCI levels |
| pci_oe | output | NPCI | PCI drive enables |
| pcif_o | output | NPCIF | PCIF levels |
| pcif_oe | output | NPCIF | PCIF drive enables |
| usb_o | output | 1 | USB level |
| usb_oe | output | 1 | USB drive enable |
| ref_o | output | 1 | REF level |
| ref_oe | output | 1 | REF drive enable |
| vco_en | output | 1 | VCO enable, 0 = VCO off |

## Verification
The bench targets the interaction of the stop masks with the two tristate choices. A design that ignored a free-run mask would freeze an SRC or PCIF output that should keep toggling. A design that swapped the drive-mode bits would float a complement side that must be driven low. It also checks the wake window: a design that honoured the tristate bits there, or released the outputs as soon as the VCO came back, would show floating true sides or running clocks before the count expires. It checks that the VCO stays on until every domain has parked and stays off for as long as the power-down request is held. A design that ignored the domain acknowledgements, or skipped the stabilization count after reset, shows up as a wrong `vco_en` or wrong outputs in those windows.

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int NCPU        = 3,
  parameter int NSRC        = 7,
  parameter int NPCI        = 6,
  parameter int NPCIF       = 3,
  parameter int STAB_CYCLES = 25773
) (
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             cpu_clk,
  input  logic             src_clk,
  input  logic             pci_clk,
  input  logic             usb_clk,
  input  logic             dot_clk,
  input  logic             pd,
  input  logic             sw_stop,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NPCI-1:0]  pci_en,
  input  logic [NPCIF-1:0] pcif_en,
  input  logic             usb_en,
  input  logic             dot_en,
  input  logic             ref_en,
  input  logic [NSRC-1:0]  src_stop_sel,
  input  logic [NPCIF-1:0] pcif_stop_sel,
  input  logic             src_stop_tri,
  input  logic [NCPU-1:0]  cpu_pd_tri,
  input  logic             src_pd_tri,
  input  logic             dot_pd_tri,
  output logic [NCPU-1:0]  cpu_p,
  output logic [NCPU-1:0]  cpu_n,
  output logic [NCPU-1:0]  cpu_p_oe,
  output logic [NCPU-1:0]  cpu_n_oe,
  output logic [NSRC-1:0]  src_p,
  output logic [NSRC-1:0]  src_n,
  output logic [NSRC-1:0]  src_p_oe,
  output logic [NSRC-1:0]  src_n_oe,
  output logic             dot_p,
  output logic             dot_n,
  output logic             dot_p_oe,
  output logic             dot_n_oe,
  output logic [NPCI-1:0]  pci_o,
  output logic [NPCI-1:0]  pci_oe,
  output logic [NPCIF-1:0] pcif_o,
  output logic [NPCIF-1:0] pcif_oe,
  output logic             usb_o,
  output logic             usb_oe,
  output logic             ref_o,
  output logic             ref_oe,
  output logic             vco_en
);
  localparam int CW   = $clog2(STAB_CYCLES + 1);
  localparam int NACK = 5;

  typedef enum logic [1:0] {S_RUN, S_PARK, S_OFF, S_WAKE} st_t;

  st_t            st, st_d;
  logic [CW-1:0]  cnt, cnt_d;
  logic           pd_m, pd_s, park_q, float_q, ref_gate;
  logic [NACK-1:0] ack_m, ack_s, ack_raw;

  // reference domain: power-down sequencer
  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    unique case (st)
      S_RUN:  if (pd_s) st_d = S_PARK;
      S_PARK: begin
        if (!pd_s) begin
          st_d  = S_WAKE;
          cnt_d = '0;
        end else if (&ack_s && !ref_gate) begin
          st_d = S_OFF;
        end
      end
      S_OFF: begin
        if (!pd_s) begin
          st_d  = S_WAKE;
          cnt_d = '0;
        end
      end
      S_WAKE: begin
        if (pd_s) st_d = S_PARK;
        else if (cnt == CW'(STAB_CYCLES - 1)) st_d = S_RUN;
        else cnt_d = cnt + 1'b1;
      end
      default: st_d = S_WAKE;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_m    <= 1'b0;
      pd_s    <= 1'b0;
      ack_m   <= '1;
      ack_s   <= '1;
      st      <= S_WAKE;
      cnt     <= '0;
      park_q  <= 1'b1;
      float_q <= 1'b0;
    end else begin
      pd_m    <= pd;
      pd_s    <= pd_m;
      ack_m   <= ack_raw;
      ack_s   <= ack_m;
      st      <= st_d;
      cnt     <= cnt_d;
      park_q  <= (st_d != S_RUN);
      float_q <= (st_d == S_PARK) || (st_d == S_OFF);
    end
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_gate <= 1'b0;
    else        ref_gate <= !park_q;
  end

  assign vco_en = (st != S_OFF);
  assign ref_o  = ref_clk & ref_gate;
  assign ref_oe = ref_en;

  a_r7_vco_after_park: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(vco_en) |-> $past(&ack_s));
  a_r8_wake_holds_park: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(vco_en) |-> park_q);
  a_r5_ref_low_when_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !vco_en |-> !ref_gate);

  // CPU pairs: park high on a rising edge
  logic cpu_pm, cpu_ps, cpu_park, cpu_fm, cpu_fs;
  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) {cpu_pm, cpu_ps, cpu_park, cpu_fm, cpu_fs} <= 5'b11100;
    else begin
      cpu_pm   <= park_q;
      cpu_ps   <= cpu_pm;
      cpu_park <= cpu_ps;
      cpu_fm   <= float_q;
      cpu_fs   <= cpu_fm;
    end
  end
  assign cpu_p    = cpu_park ? '1 : {NCPU{cpu_clk}};
  assign cpu_n    = cpu_park ? '0 : {NCPU{~cpu_clk}};
  assign cpu_p_oe = cpu_en & ~({NCPU{cpu_park & cpu_fs}} & cpu_pd_tri);
  assign cpu_n_oe = cpu_en & {NCPU{~cpu_park}};

  // dot pair
  logic dot_pm, dot_ps, dot_park, dot_fm, dot_fs;
  always_ff @(posedge dot_clk or negedge rst_n) begin
    if (!rst_n) {dot_pm, dot_ps, dot_park, dot_fm, dot_fs} <= 5'b11100;
    else begin
      dot_pm   <= park_q;
      dot_ps   <= dot_pm;
      dot_park <= dot_ps;
      dot_fm   <= float_q;
      dot_fs   <= dot_fm;
    end
  end
  assign dot_p    = dot_park | dot_clk;
  assign dot_n    = ~dot_park & ~dot_clk;
  assign dot_p_oe = dot_en & ~(dot_park & dot_fs & dot_pd_tri);
  assign dot_n_oe = dot_en & ~dot_park;

  // SRC pairs: power-down park plus selective software stop
  logic            src_pm, src_ps, src_fm, src_fs, src_sm, src_ss, src_pdp;
  logic [NSRC-1:0] src_stp, src_hold;
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      {src_pm, src_ps, src_pdp} <= 3'b111;
      {src_fm, src_fs, src_sm, src_ss} <= 4'b0000;
      src_stp <= '0;
    end else begin
      src_pm  <= park_q;
      src_ps  <= src_pm;
      src_pdp <= src_ps;
      src_fm  <= float_q;
      src_fs  <= src_fm;
      src_sm  <= sw_stop;
      src_ss  <= src_sm;
      src_stp <= src_ss ? src_stop_sel : '0;
    end
  end
  assign src_hold = {NSRC{src_pdp}} | src_stp;
  assign src_p    = src_hold | {NSRC{src_clk}};
  assign src_n    = ~src_hold & {NSRC{~src_clk}};
  assign src_p_oe = src_en & ~{NSRC{src_pdp & src_fs & src_pd_tri}}
                  & ~(src_stp & {NSRC{~src_pdp & src_stop_tri}});
  assign src_n_oe = src_en & {NSRC{~src_pdp}};

  a_r2_stop_needs_select: assert property (@(posedge src_clk) disable iff (!rst_n)
    (src_stp & ~$past(src_stop_sel)) == '0);

  // PCI and PCIF: park low on a falling edge
  logic             pci_pm, pci_ps, pci_sm, pci_ss, pci_g, pci_pdg;
  logic [NPCIF-1:0] pcif_g;
  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) {pci_pm, pci_ps, pci_sm, pci_ss} <= 4'b1100;
    else begin
      pci_pm <= park_q;
      pci_ps <= pci_pm;
      pci_sm <= sw_stop;
      pci_ss <= pci_sm;
    end
  end
  always_ff @(negedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_g   <= 1'b0;
      pcif_g  <= '0;
      pci_pdg <= 1'b1;
    end else begin
      pci_g   <= ~(pci_ps | pci_ss);
      pcif_g  <= ~({NPCIF{pci_ps}} | ({NPCIF{pci_ss}} & pcif_stop_sel));
      pci_pdg <= pci_ps;
    end
  end
  assign pci_o   = {NPCI{pci_clk & pci_g}};
  assign pci_oe  = pci_en;
  assign pcif_o  = {NPCIF{pci_clk}} & pcif_g;
  assign pcif_oe = pcif_en;

  a_r5_pci_parked_low: assert property (@(negedge pci_clk) disable iff (!rst_n)
    pci_pdg |-> (!pci_g && pcif_g == '0));

  // USB
  logic usb_pm, usb_ps, usb_g;
  always_ff @(posedge usb_clk or negedge rst_n) begin
    if (!rst_n) {usb_pm, usb_ps} <= 2'b11;
    else begin
      usb_pm <= park_q;
      usb_ps <= usb_pm;
    end
  end
  always_ff @(negedge usb_clk or negedge rst_n) begin
    if (!rst_n) usb_g <= 1'b0;
    else        usb_g <= !usb_ps;
  end
  assign usb_o  = usb_clk & usb_g;
  assign usb_oe = usb_en;

  assign ack_raw = {cpu_park, src_pdp, pci_pdg, ~usb_g, dot_park};
endmodule

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_clk_stop_gate;
  localparam int NCPU = 3, NSRC = 7, NPCI = 6, NPCIF = 3, STAB = 40;

  logic rst_n = 0, ref_clk = 0, cpu_clk = 0, src_clk = 0, pci_clk = 0, usb_clk = 0, dot_clk = 0;
  logic pd = 0, sw_stop = 0;
  logic [NCPU-1:0] cpu_en = '1, cpu_pd_tri = '0;
  logic [NSRC-1:0] src_en = '1, src_stop_sel = '0;
  logic [NPCI-1:0] pci_en = '1;
  logic [NPCIF-1:0] pcif_en = '1, pcif_stop_sel = '0;
  logic usb_en = 1, dot_en = 1, ref_en = 1, src_stop_tri = 0, src_pd_tri = 0, dot_pd_tri = 0;
  logic [NCPU-1:0] cpu_p, cpu_n, cpu_p_oe, cpu_n_oe;
  logic [NSRC-1:0] src_p, src_n, src_p_oe, src_n_oe;
  logic dot_p, dot_n, dot_p_oe, dot_n_oe, usb_o, usb_oe, ref_o, ref_oe, vco_en;
  logic [NPCI-1:0] pci_o, pci_oe;
  logic [NPCIF-1:0] pcif_o, pcif_oe;

  always #10 ref_clk = ~ref_clk;
  always #3  cpu_clk = ~cpu_clk;
  always #5  src_clk = ~src_clk;
  always #15 pci_clk = ~pci_clk;
  always #7  usb_clk = ~usb_clk;
  always #4  dot_clk = ~dot_clk;

  clk_stop_gate #(.NCPU(NCPU), .NSRC(NSRC), .NPCI(NPCI), .NPCIF(NPCIF), .STAB_CYCLES(STAB)) u0 (
    .rst_n, .ref_clk, .cpu_clk, .src_clk, .pci_clk, .usb_clk, .dot_clk, .pd, .sw_stop,
    .cpu_en, .src_en, .pci_en, .pcif_en, .usb_en, .dot_en, .ref_en,
    .src_stop_sel, .pcif_stop_sel, .src_stop_tri, .cpu_pd_tri, .src_pd_tri, .dot_pd_tri,
    .cpu_p, .cpu_n, .cpu_p_oe, .cpu_n_oe, .src_p, .src_n, .src_p_oe, .src_n_oe,
    .dot_p, .dot_n, .dot_p_oe, .dot_n_oe, .pci_o, .pci_oe, .pcif_o, .pcif_oe,
    .usb_o, .usb_oe, .ref_o, .ref_oe, .vco_en);

  int checks = 0, failures = 0;
  int ph = 2;  // 0 running, 1 powered down, 2 wake hold

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NSRC-1:0] exp_src_stop();
    return (ph == 0 && sw_stop) ? src_stop_sel : '0;
  endfunction

  function automatic logic [NPCIF-1:0] exp_pcif_run();
    if (ph != 0) return '0;
    return sw_stop ? ~pcif_stop_sel : '1;
  endfunction

  task automatic check_all(input string ov);
    logic parked;
    logic [NCPU-1:0] cpoe, cnoe, cp, cn;
    logic [NSRC-1:0] stp, hold, spoe, snoe, sp, sn;
    logic [NPCI-1:0] pe;
    logic [NPCIF-1:0] fe;
    logic dpoe, dnoe;
    string tp, ts, tg, tu, tv;
    parked = (ph != 0);
    if (ph == 1) begin tp = "R6"; ts = "R6"; tg = "R5"; tu = "R5"; tv = "R7"; end
    else if (ph == 2) begin tp = ov; ts = ov; tg = ov; tu = ov; tv = ov; end
    else if (ov != "") begin tp = ov; ts = ov; tg = ov; tu = ov; tv = ov; end
    else begin
      tp = sw_stop ? "R4" : "R1"; ts = sw_stop ? "R3" : "R1";
      tg = sw_stop ? "R2" : "R1"; tu = sw_stop ? "R4" : "R1"; tv = "R1";
    end
    cpoe = cpu_en & ~((ph == 1) ? cpu_pd_tri : '0);
    cnoe = parked ? '0 : cpu_en;
    cp   = parked ? '1 : {NCPU{cpu_clk}};
    cn   = parked ? '0 : {NCPU{~cpu_clk}};
    chk(tp, "cpu_p_oe", 32'(cpu_p_oe), 32'(cpoe));
    chk(tp, "cpu_n_oe", 32'(cpu_n_oe), 32'(cnoe));
    chk(tp, "cpu_p", 32'(cpu_p & cpoe), 32'(cp & cpoe));
    chk(tp, "cpu_n", 32'(cpu_n & cnoe), 32'(cn & cnoe));
    stp  = exp_src_stop();
    hold = parked ? '1 : stp;
    spoe = src_en & ~((ph == 1 && src_pd_tri) ? '1 : '0) & ~(src_stop_tri ? stp : '0);
    snoe = parked ? '0 : src_en;
    sp   = hold | {NSRC{src_clk}};
    sn   = ~hold & {NSRC{~src_clk}};
    chk(ts, "src_p_oe", 32'(src_p_oe), 32'(spoe));
    chk(ts, "src_n_oe", 32'(src_n_oe), 32'(snoe));
    chk(ts, "src_p", 32'(src_p & spoe), 32'(sp & spoe));
    chk(ts, "src_n", 32'(src_n & snoe), 32'(sn & snoe));
    dpoe = dot_en & ~(ph == 1 && dot_pd_tri);
    dnoe = dot_en & !parked;
    chk(tp, "dot_oe", 32'({dot_p_oe, dot_n_oe}), 32'({dpoe, dnoe}));
    chk(tp, "dot_lvl", 32'({dot_p & dpoe, dot_n & dnoe}),
        32'({(parked | dot_clk) & dpoe, (!parked & !dot_clk) & dnoe}));
    pe = (ph == 0 && !sw_stop) ? {NPCI{pci_clk}} : '0;
    chk(tg, "pci_oe", 32'(pci_oe), 32'(pci_en));
    chk(tg, "pci_o", 32'(pci_o & pci_en), 32'(pe & pci_en));
    fe = exp_pcif_run() & {NPCIF{pci_clk}};
    chk(tg, "pcif_oe", 32'(pcif_oe), 32'(pcif_en));
    chk(tg, "pcif_o", 32'(pcif_o & pcif_en), 32'(fe & pcif_en));
    chk(tu, "usb", 32'({usb_oe, usb_o & usb_en}), 32'({usb_en, (ph == 0) & usb_clk & usb_en}));
    chk(tu, "ref", 32'({ref_oe, ref_o & ref_en}), 32'({ref_en, (ph == 0) & ref_clk & ref_en}));
    chk(tv, "vco_en", 32'(vco_en), 32'(ph != 1));
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge ref_clk);
  endtask

  task automatic sample4(input string ov);
    repeat (4) begin
      #2.3;
      check_all(ov);
    end
  endtask

  task automatic pd_cycle(input string wtag);
    pd = 1; settle(30); ph = 1; sample4("");
    pd = 0; settle(10); ph = 2; sample4(wtag);
    settle(STAB + 30); ph = 0; sample4("");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    settle(5);
    #1 rst_n = 1;
    settle(3); ph = 2; sample4("R9");
    settle(STAB + 30); ph = 0; sample4("R9");
    // stop with every output free-running
    sw_stop = 1; settle(12); sample4("R2");
    // stop everything selectable, true side driven
    src_stop_sel = '1; pcif_stop_sel = 3'b101; settle(12); sample4("");
    // stopped true side floats
    src_stop_tri = 1; settle(2); sample4("");
    // disabled outputs
    sw_stop = 0; cpu_en = 3'b010; src_en = 7'b1010011; pci_en = 6'b001100; pcif_en = 3'b010;
    usb_en = 0; dot_en = 0; settle(12); sample4("R1");
    cpu_en = '1; src_en = '1; pci_en = '1; pcif_en = '1; usb_en = 1; dot_en = 1;
    // power-down with mixed tristate modes
    cpu_pd_tri = 3'b101; src_pd_tri = 1; dot_pd_tri = 0;
    pd_cycle("R8");
    cpu_pd_tri = 3'b010; src_pd_tri = 0; dot_pd_tri = 1;
    pd_cycle("R8");
    // random rounds
    for (int r = 0; r < 8; r++) begin
      cpu_en = NCPU'($urandom | $urandom); src_en = NSRC'($urandom | $urandom);
      pci_en = NPCI'($urandom | $urandom); pcif_en = NPCIF'($urandom | $urandom);
      usb_en = 1'($urandom); dot_en = 1'($urandom | $urandom); ref_en = 1'($urandom | $urandom);
      src_stop_sel = NSRC'($urandom); pcif_stop_sel = NPCIF'($urandom);
      src_stop_tri = 1'($urandom); cpu_pd_tri = NCPU'($urandom);
      src_pd_tri = 1'($urandom); dot_pd_tri = 1'($urandom); sw_stop = 1'($urandom);
      settle(12); ph = 0; sample4("");
      pd_cycle("R8");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge ref_clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule